// File: doc/BRIEF.md
# Four-Lane Reciprocal Frequency Meter

This block measures the frequency of four unrelated digital pulse inputs at once. Each input has its own measurement lane. A lane brings its input into the reference clock domain and counts reference cycles from one rising edge to the next. It then divides the reference rate, expressed in kHz, by that count. The quotient leaves the lane as an unsigned binary kHz value together with a one-cycle valid strobe. Decimal conversion and display are left to downstream logic.

The reference clock is nominally 200 MHz, so the default `REF_KHZ` is 200000. At that rate the largest possible result, 100000 kHz for a two-cycle period, fits in six decimal digits. Resolution is the truncated quotient. For example, a 2400-cycle period gives 83 kHz and a 1200-cycle period gives 166 kHz.

The result path has no back-pressure. There is no ready input, so a consumer must capture a lane's value in the cycle its strobe is high. Between strobes the lane's output field holds its last value. A lane whose input stops for longer than its counter range emits a single 0 kHz result and then waits to be re-armed by fresh edges.

Top module: `quad_recip_freq_meter`

## Requirements
- R1: While reset is asserted and after it is released, every `khz_valid` bit is low and every `khz_out` field is 0 until that lane produces its first result.
- R2: The first rising edge a lane sees after reset, or after it has reported a timeout, produces no result. Only the edges after it do.
- R3: For two consecutive rising edges P reference cycles apart, the lane reports floor(REF_KHZ / P) in `khz_out[i*RES_W +: RES_W]` for lane i.
- R4: `khz_valid[i]` is high for exactly one cycle per result, and never in two consecutive cycles.
- R5: If 2^PER_W − 1 reference cycles pass with no rising edge, the lane reports exactly one result of value 0 and disarms. A period of 2^PER_W − 2 cycles is still measured normally.
- R6: The lanes are independent. Each lane's results depend only on its own input, whatever the other inputs do.
- R7: An input whose period is shorter than the divider's run time, down to 2 cycles, still yields correct values. Edges that arrive while the divider is busy start no division, and rising edges seen by a lane are at least 2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (nominally 200 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | LANES | Asynchronous pulse inputs, one per lane |
| khz_valid | output | LANES | One-cycle result strobe per lane |
| khz_out | output | LANES*RES_W | Lane i result in kHz at bits [i*RES_W +: RES_W] |

## Verification
The hardest state to reach from the ports is the timeout. The input must go quiet for the whole counter range right after any in-flight division has drained, and then be re-armed so that the first new edge can be shown to stay silent. The bench uses a narrow counter so that this takes a few thousand cycles. It stops all inputs, waits out the last division, counts results across the full timeout window, and restarts the lanes with a window that closes before any second edge. Fast inputs at 2 to 19 cycles exercise the dropped-edge case, because edges land while the divider is still working.

// File: rtl/fm_pkg.sv
package fm_pkg;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

  // bits needed to hold values 0..v
  function automatic int width_for(input int v);
    return $clog2(v + 1);
  endfunction

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  // sh[STAGES-1] is the synchronised sample, sh[STAGES] the one before it
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R7: two rising edges are never reported back to back
  p_rise_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/fm_period_counter.sv
module fm_period_counter #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic             meas,
  output logic             timeout,
  output logic [PER_W-1:0] period
);

  localparam logic [PER_W-1:0] SAT  = '1;
  localparam logic [PER_W-1:0] NEAR = SAT - PER_W'(1);

  logic [PER_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (rise) begin
      cnt   <= PER_W'(1);
      armed <= 1'b1;
    end else if (cnt != SAT) begin
      cnt <= cnt + PER_W'(1);
      if (cnt == NEAR) armed <= 1'b0;
    end
  end

  assign meas    = rise && armed;
  assign timeout = !rise && (cnt == NEAR);
  assign period  = cnt;

  // R5: a saturated count stays saturated until an edge arrives
  p_hold_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == SAT && !rise) |=> (cnt == SAT));

endmodule

// File: rtl/fm_recip_div.sv
module fm_recip_div
  import fm_pkg::*;
#(
  parameter int DVD = 200000,
  parameter int Q_W = 18,
  parameter int D_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [D_W-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [Q_W-1:0] quotient
);

  localparam int              STEP_W   = $clog2(Q_W + 1);
  localparam logic [Q_W-1:0]  DVD_BITS = Q_W'(DVD);

  div_state_e        st;
  logic [D_W-1:0]    rem;
  logic [D_W-1:0]    dsr;
  logic [Q_W-1:0]    q;
  logic [STEP_W-1:0] steps;
  logic [D_W:0]      trial;
  logic [D_W:0]      diff;

  always_comb begin
    trial = {rem, q[Q_W-1]};
    diff  = trial - {1'b0, dsr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= DIV_IDLE;
      rem   <= '0;
      dsr   <= '0;
      q     <= '0;
      steps <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        DIV_IDLE: begin
          if (start) begin
            dsr   <= divisor;
            q     <= DVD_BITS;
            rem   <= '0;
            steps <= STEP_W'(Q_W);
            st    <= DIV_RUN;
          end
        end
        DIV_RUN: begin
          if (!diff[D_W]) begin
            rem <= diff[D_W-1:0];
            q   <= {q[Q_W-2:0], 1'b1};
          end else begin
            rem <= trial[D_W-1:0];
            q   <= {q[Q_W-2:0], 1'b0};
          end
          steps <= steps - STEP_W'(1);
          if (steps == STEP_W'(1)) begin
            st   <= DIV_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= DIV_IDLE;
      endcase
    end
  end

  assign busy     = (st == DIV_RUN);
  assign quotient = q;

  // R3: the finished quotient is the floor of dividend over divisor
  p_quot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((longint'(q) * longint'(dsr) <= longint'(DVD)) &&
              (longint'(DVD) < (longint'(q) + 1) * longint'(dsr))));

endmodule

// File: rtl/fm_lane.sv
module fm_lane #(
  parameter int REF_KHZ     = 200000,
  parameter int RES_W       = 18,
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig,
  output logic             out_valid,
  output logic [RES_W-1:0] out_khz
);

  logic             rise;
  logic             meas;
  logic             timeout;
  logic [PER_W-1:0] period;
  logic             busy;
  logic             done;
  logic [RES_W-1:0] quotient;
  logic             start;

  fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sig), .rise(rise)
  );

  fm_period_counter #(.PER_W(PER_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise(rise),
    .meas(meas), .timeout(timeout), .period(period)
  );

  // an edge that lands while the divider works is dropped
  assign start = meas && !busy;

  fm_recip_div #(.DVD(REF_KHZ), .Q_W(RES_W), .D_W(PER_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .divisor(period),
    .busy(busy), .done(done), .quotient(quotient)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_khz   <= '0;
    end else begin
      out_valid <= timeout | done;
      if (timeout)   out_khz <= '0;
      else if (done) out_khz <= quotient;
    end
  end

  // R4: each result strobe lasts one cycle
  p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: a timeout never coincides with a finished division
  p_no_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout && done));

endmodule

// File: rtl/quad_recip_freq_meter.sv
module quad_recip_freq_meter #(
  parameter int LANES       = 4,
  parameter int REF_KHZ     = 200000,
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RES_W       = fm_pkg::width_for(REF_KHZ)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       sig_in,
  output logic [LANES-1:0]       khz_valid,
  output logic [LANES*RES_W-1:0] khz_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fm_lane #(
      .REF_KHZ(REF_KHZ), .RES_W(RES_W), .PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_lane (
      .clk(clk),
      .rst_n(rst_n),
      .sig(sig_in[g]),
      .out_valid(khz_valid[g]),
      .out_khz(khz_out[g*RES_W +: RES_W])
    );
  end

endmodule

// File: tb/tb_quad_recip_freq_meter.sv
module tb_quad_recip_freq_meter;

  localparam int LANES = 4;
  localparam int REF   = 200000;
  localparam int PW    = 12;
  localparam int RW    = 18;
  localparam int SAT   = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  wire  [LANES-1:0]    sig;
  wire  [LANES-1:0]    vld;
  wire  [LANES*RW-1:0] khz;

  int    per[LANES];
  int    exp_v[LANES];
  int    nres[LANES];
  bit    pv[LANES];
  bit    win = 1'b0;
  bit    over = 1'b0;
  string tag = "";
  int    tests = 0;
  int    fails = 0;
  int    oldmax = 0;

  quad_recip_freq_meter #(.LANES(LANES), .REF_KHZ(REF), .PER_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig), .khz_valid(vld), .khz_out(khz)
  );

  always #5 clk = ~clk;

  initial for (int i = 0; i < LANES; i++) begin
    per[i] = 0; exp_v[i] = 0; nres[i] = 0; pv[i] = 1'b0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_src
    logic s = 1'b0;
    assign sig[g] = s;
    always begin
      if (per[g] < 2) begin
        s = 1'b0;
        @(negedge clk);
      end else begin
        s = 1'b1;
        repeat (per[g] / 2) @(negedge clk);
        s = 1'b0;
        repeat (per[g] - per[g] / 2) @(negedge clk);
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !over) begin
      for (int i = 0; i < LANES; i++) begin
        if (vld[i]) begin
          nres[i]++;
          if (pv[i]) check(1'b0, "R4 strobe longer than one cycle", 2, 1);
          if (win) check(khz[i*RW +: RW] == RW'(exp_v[i]), tag,
                         longint'(khz[i*RW +: RW]), exp_v[i]);
        end
        pv[i] = vld[i];
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < LANES; i++) nres[i] = 0;
  endtask

  function automatic int set_per(input int a, input int b, input int c, input int d);
    int m;
    per[0] = a; per[1] = b; per[2] = c; per[3] = d;
    m = 0;
    for (int i = 0; i < LANES; i++) begin
      exp_v[i] = (per[i] >= 2) ? REF / per[i] : 0;
      if (per[i] > m) m = per[i];
    end
    return m;
  endfunction

  task automatic measure(input int a, input int b, input int c, input int d, input string t);
    int m;
    m = set_per(a, b, c, d);
    cyc(oldmax + 2 * m + RW + 20);
    clear_counts();
    tag = t;
    win = 1'b1;
    cyc(3 * m + RW + 20);
    win = 1'b0;
    for (int i = 0; i < LANES; i++)
      check(nres[i] >= 1, {t, " result count"}, nres[i], 1);
    oldmax = m;
  endtask

  // R2: after (re)arming, the first edge must stay silent
  task automatic rearm(input int a, input int b, input int c, input int d, input string t);
    int m;
    int lo;
    m = set_per(a, b, c, d);
    lo = a;
    if (b < lo) lo = b;
    if (c < lo) lo = c;
    if (d < lo) lo = d;
    clear_counts();
    cyc(lo - 5);
    for (int i = 0; i < LANES; i++) check(nres[i] == 0, t, nres[i], 0);
    measure(a, b, c, d, "R3 values after re-arm");
    oldmax = m;
  endtask

  task automatic finish_run();
    over = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1_900_000;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    // R1: quiet outputs after reset
    for (int k = 0; k < 4; k++) begin
      cyc(4);
      check(vld == '0, "R1 valid after reset", longint'(vld), 0);
      check(khz == '0, "R1 value after reset", longint'(khz[RW-1:0]), 0);
    end

    rearm(100, 130, 170, 220, "R2 first edge after reset");
    measure(2400, 2000, 1600, 1200, "R3 test tones 83/100/125/166 kHz");

    for (int k = 0; k < 10; k++) begin
      measure(2 + 53 * k, 19 + 53 * k, 36 + 53 * k, 53 + 53 * k,
              (k == 0) ? "R7 periods shorter than divider" : "R3 period sweep");
    end

    measure(7, 611, 13, 1999, "R6 independent mixed lanes");

    // R5: all inputs stop, one zero result per lane
    void'(set_per(0, 0, 0, 0));
    cyc(oldmax + 40);
    clear_counts();
    tag = "R5 timeout value";
    win = 1'b1;
    cyc(SAT + 200);
    win = 1'b0;
    for (int i = 0; i < LANES; i++)
      check(nres[i] == 1, "R5 single timeout result", nres[i], 1);
    oldmax = 0;

    rearm(150, 160, 170, 180, "R2 first edge after timeout");

    measure(SAT - 1, SAT - 1, SAT - 1, SAT - 1, "R5 longest period still measured");

    finish_run();
  end

endmodule